// File: doc/BRIEF.md
# Receive Descriptor Ring

This block keeps a small ring of receive descriptors that hand frame buffers back and forth between a byte-stream frame receiver and a consumer. Each descriptor carries a status word, a stored length and a buffer base address. Every descriptor starts out empty, which means the receiver owns it. An arriving frame is written byte by byte, through a write strobe, into the buffer of the receiver's current descriptor. When the frame ends, the receiver closes the descriptor and clears its empty flag, which hands it to the consumer. The consumer reads the payload length and the status, then gives the descriptor back with a one-cycle return pulse.

The receiver runs a three-state machine. `ST_IDLE` waits for the first byte of a frame. `ST_FILL` accepts the bytes of a frame whose descriptor was empty when the frame started. `ST_DROP` throws away a frame that met a descriptor still held by the consumer. The transitions are as follows. From `ST_IDLE`, a first byte without the last flag goes to `ST_FILL` when the current descriptor is empty, or to `ST_DROP` when it is not. A one-byte frame stays in `ST_IDLE`: it closes the descriptor, or it is dropped. From `ST_FILL` or `ST_DROP`, the byte that carries the last flag returns the machine to `ST_IDLE`.

Only the last descriptor carries the wrap flag. Both the receiver index and the consumer index move on to the next descriptor after each use, and go back to 0 after the last one. A frame longer than the buffer limit is cut off and flagged. A frame shorter than the check sequence is flagged as a runt. Any nonzero error field means the consumer is given no payload. The descriptor is still recycled normally.

Top module: `rx_bd_ring`

## Requirements
- R1: After reset, every descriptor is empty and the consumer index is 0. rd_valid is 0, rd_status reads 16'h8000 (bit 15 = empty), ovr_pulse is 0 and mem_we is 0.
- R2: Each byte of an accepted frame raises mem_we in the same cycle it is presented. mem_addr equals the current descriptor's base address plus the byte's offset within the frame, and mem_data equals in_data.
- R3: The cycle after the last byte of an accepted frame, the descriptor at the consumer index is full: rd_valid=1 and rd_ok=1. rd_len equals the received byte count minus 4, because the stored count includes the 4-byte check sequence.
- R4: Only the last descriptor (index DEPTH-1) shows the wrap flag, rd_status bit 13. After the last descriptor, both the receiver and the consumer return to descriptor 0.
- R5: When the descriptor at the consumer index is empty, rd_valid is 0 and no frame is reported. A return pulse in that state is ignored and the consumer index does not move.
- R6: rd_status bits 5:0 are error flags: bit 5 = oversize, bit 4 = runt, bits 3:0 = in_err sampled with the last byte. If any of them is set, rd_ok=0 and rd_len=0, and the descriptor is recycled on return as usual.
- R7: A frame with more than MAX_LEN bytes (default 1520) writes only its first MAX_LEN bytes. It stores length MAX_LEN and sets status bit 5. A frame of exactly MAX_LEN bytes is delivered without error.
- R8: A frame of fewer than 4 bytes sets status bit 4.
- R9: A frame whose first byte finds the receiver's current descriptor not empty is dropped whole. No mem_we is raised, the descriptors and the receiver index stay as they were, and ovr_pulse is high for exactly the one cycle after that first byte.
- R10: A return pulse while rd_valid=1 makes the descriptor empty again and moves the consumer index on by one. From the next cycle the outputs show the next descriptor.
- R11: A write with cfg_we sets the buffer base of descriptor cfg_idx. Later frames into that descriptor are written from the new base, and rd_addr reports it. After reset, descriptor i has base i*BUF_SPAN (default 2048).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_err | input | 4 | Receive error code, sampled with the final byte |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_data | output | 8 | Buffer byte data |
| ovr_pulse | output | 1 | One-cycle pulse: a frame was dropped because no descriptor was free |
| cfg_we | input | 1 | Buffer base write strobe |
| cfg_idx | input | IDX_W | Descriptor selected by cfg_we |
| cfg_addr | input | ADDR_W | New buffer base |
| rd_valid | output | 1 | The descriptor at the consumer index holds a frame |
| rd_len | output | LEN_W | Payload length without the check sequence, or 0 on error |
| rd_status | output | 16 | Bit 15 empty, bit 13 wrap, bits 5:0 error flags |
| rd_addr | output | ADDR_W | Buffer base of the descriptor at the consumer index |
| rd_ok | output | 1 | Frame is valid and its payload may be used |
| rd_ret | input | 1 | One-cycle return of the shown descriptor |

## Verification
Byte writes are combinational and are due in the same cycle as the byte. The bench drives each byte at the falling edge and samples mem_we and mem_addr just after it. The handoff of a closed descriptor passes through one register, so the bench checks rd_valid, rd_len, rd_status and rd_addr at the falling edge that follows the last byte. ovr_pulse also comes from one register and is expected at the falling edge after the first byte of a dropped frame. A return pulse is registered, so the next descriptor's fields are read one falling edge after the pulse.

// File: rtl/rx_bd_pkg.sv
package rx_bd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DROP
    } rx_state_e;

    localparam int FCS_BYTES   = 4;
    localparam int STAT_W      = 16;
    localparam int ERR_W       = 6;
    localparam int CODE_W      = 4;

endpackage

// File: rtl/rx_bd_fsm.sv
module rx_bd_fsm
    import rx_bd_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MAX_LEN = 1520,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [CODE_W-1:0]   in_err,
    input  logic                cur_empty,
    output logic [IDX_W-1:0]    wr_idx,
    output logic                byte_we,
    output logic [LEN_W-1:0]    byte_off,
    output logic                close,
    output logic [LEN_W-1:0]    close_len,
    output logic [ERR_W-1:0]    close_err,
    output logic                ovr_pulse
);

    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);

    rx_state_e          state_q, state_nx;
    logic [LEN_W-1:0]   cnt_q, cnt_eff;
    logic               oversz_q, oversz_nx;
    logic               start, own_start, room;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx  = state_q;
        start     = 1'b0;
        own_start = 1'b0;
        cnt_eff   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_eff   = '0;
                start     = in_valid;
                own_start = in_valid && cur_empty;
                if (in_valid && !in_last)
                    state_nx = cur_empty ? ST_FILL : ST_DROP;
            end
            ST_FILL: begin
                if (in_valid && in_last) state_nx = ST_IDLE;
            end
            ST_DROP: begin
                if (in_valid && in_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        room      = (cnt_eff < LIMIT);
        oversz_nx = ((state_q == ST_FILL) && oversz_q) || (in_valid && !room);
        byte_we   = in_valid && room && (own_start || (state_q == ST_FILL));
        byte_off  = cnt_eff;
        close     = in_valid && in_last && (own_start || (state_q == ST_FILL));
        close_len = room ? cnt_eff + LEN_W'(1) : cnt_eff;
        close_err = {oversz_nx, (close_len < LEN_W'(FCS_BYTES)), in_err};
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            oversz_q  <= 1'b0;
            wr_idx    <= '0;
            ovr_pulse <= 1'b0;
        end else begin
            ovr_pulse <= start && !cur_empty;
            if (state_nx == ST_FILL) begin
                cnt_q    <= byte_we ? cnt_eff + LEN_W'(1) : cnt_eff;
                oversz_q <= oversz_nx;
            end else begin
                cnt_q    <= '0;
                oversz_q <= 1'b0;
            end
            if (close)
                wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/rx_bd_table.sv
module rx_bd_table
    import rx_bd_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int ADDR_W   = 16,
    parameter int BUF_SPAN = 2048,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int LEN_W    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                close,
    input  logic [LEN_W-1:0]    close_len,
    input  logic [ERR_W-1:0]    close_err,
    input  logic                ret,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_addr,
    output logic                wr_empty,
    output logic [ADDR_W-1:0]   wr_base,
    output logic                rd_empty,
    output logic                rd_wrap,
    output logic [LEN_W-1:0]    rd_len_raw,
    output logic [ERR_W-1:0]    rd_err,
    output logic [ADDR_W-1:0]   rd_base
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0]   empty_q;
    logic [DEPTH-1:0]   wrap_flag;
    logic [LEN_W-1:0]   len_q  [DEPTH];
    logic [ERR_W-1:0]   err_q  [DEPTH];
    logic [ADDR_W-1:0]  base_q [DEPTH];
    logic [IDX_W-1:0]   rd_idx;
    logic               ret_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_wrap
        assign wrap_flag[g] = (g == DEPTH - 1);
    end

    assign ret_ok = ret && !empty_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= '1;
            rd_idx  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                len_q[i]  <= '0;
                err_q[i]  <= '0;
                base_q[i] <= ADDR_W'(i * BUF_SPAN);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (close && (wr_idx == IDX_W'(i))) begin
                    empty_q[i] <= 1'b0;
                    len_q[i]   <= close_len;
                    err_q[i]   <= close_err;
                end else if (ret_ok && (rd_idx == IDX_W'(i))) begin
                    empty_q[i] <= 1'b1;
                    len_q[i]   <= '0;
                    err_q[i]   <= '0;
                end
                if (cfg_we && (cfg_idx == IDX_W'(i)))
                    base_q[i] <= cfg_addr;
            end
            if (ret_ok)
                rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + IDX_W'(1);
        end
    end

    assign wr_empty   = empty_q[wr_idx];
    assign wr_base    = base_q[wr_idx];
    assign rd_empty   = empty_q[rd_idx];
    assign rd_wrap    = wrap_flag[rd_idx];
    assign rd_len_raw = len_q[rd_idx];
    assign rd_err     = err_q[rd_idx];
    assign rd_base    = base_q[rd_idx];

endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
    import rx_bd_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int MAX_LEN  = 1520,
    parameter int ADDR_W   = 16,
    parameter int BUF_SPAN = 2048,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    input  logic [3:0]          in_err,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_data,
    output logic                ovr_pulse,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_addr,
    output logic                rd_valid,
    output logic [LEN_W-1:0]    rd_len,
    output logic [15:0]         rd_status,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_ok,
    input  logic                rd_ret
);

    logic [IDX_W-1:0]   wr_idx;
    logic               byte_we, close, wr_empty, rd_empty, rd_wrap;
    logic [LEN_W-1:0]   byte_off, close_len, rd_len_raw;
    logic [ERR_W-1:0]   close_err, rd_err;
    logic [ADDR_W-1:0]  wr_base, rd_base;

    rx_bd_fsm #(
        .DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_last(in_last), .in_err(in_err),
        .cur_empty(wr_empty),
        .wr_idx(wr_idx), .byte_we(byte_we), .byte_off(byte_off),
        .close(close), .close_len(close_len), .close_err(close_err),
        .ovr_pulse(ovr_pulse)
    );

    rx_bd_table #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUF_SPAN(BUF_SPAN),
        .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_idx(wr_idx), .close(close), .close_len(close_len),
        .close_err(close_err), .ret(rd_ret),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
        .wr_empty(wr_empty), .wr_base(wr_base),
        .rd_empty(rd_empty), .rd_wrap(rd_wrap), .rd_len_raw(rd_len_raw),
        .rd_err(rd_err), .rd_base(rd_base)
    );

    assign mem_we    = byte_we;
    assign mem_addr  = wr_base + ADDR_W'(byte_off);
    assign mem_data  = in_data;
    assign rd_valid  = !rd_empty;
    assign rd_status = {rd_empty, 1'b0, rd_wrap, 7'b0, rd_err};
    assign rd_ok     = !rd_empty && (rd_err == '0);
    assign rd_len    = rd_ok ? rd_len_raw - LEN_W'(FCS_BYTES) : '0;
    assign rd_addr   = rd_base;

endmodule

// File: rtl/rx_bd_ring_chk.sv
module rx_bd_ring_chk #(
    parameter int MAX_LEN = 1520,
    parameter int LEN_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             mem_we,
    input logic             ovr_pulse,
    input logic             rd_valid,
    input logic [LEN_W-1:0] rd_len,
    input logic [15:0]      rd_status,
    input logic             rd_ok,
    input logic             rd_ret
);

    logic [LEN_W:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   wcnt <= '0;
        else if (in_valid && in_last) wcnt <= '0;
        else if (mem_we)              wcnt <= wcnt + 1'b1;
    end

    // R7
    oversize_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wcnt < (LEN_W+1)'(MAX_LEN)));

    // R9
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> ($past(in_valid) && !$past(mem_we)));

    // R3
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($past(in_valid && in_last) || $past(rd_ret)));

    // R6
    err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_status[5:0] != 6'd0)) |-> (!rd_ok && rd_len == '0));

    // R5
    empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_ret && !(in_valid && in_last)) |=> !rd_valid);

endmodule

bind rx_bd_ring rx_bd_ring_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .mem_we(mem_we), .ovr_pulse(ovr_pulse), .rd_valid(rd_valid),
    .rd_len(rd_len), .rd_status(rd_status), .rd_ok(rd_ok), .rd_ret(rd_ret)
);

// File: tb/test_rx_bd_ring.sv
`timescale 1ns/1ps
module test_rx_bd_ring;

    localparam int MAXL = 1520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic [3:0]  in_err = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_addr = '0;
    logic        rd_ret = 1'b0;
    logic        mem_we, ovr_pulse, rd_valid, rd_ok;
    logic [15:0] mem_addr, rd_status, rd_addr;
    logic [7:0]  mem_data;
    logic [10:0] rd_len;

    int checks = 0, fails = 0;
    int nwe, nbad, novr;

    always #4 clk = ~clk;

    rx_bd_ring i_rx_bd_ring (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .ovr_pulse(ovr_pulse),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
        .rd_valid(rd_valid), .rd_len(rd_len), .rd_status(rd_status),
        .rd_addr(rd_addr), .rd_ok(rd_ok), .rd_ret(rd_ret)
    );

    // frame length, error code, expected payload length, expected error flags
    localparam logic [32:0] VEC [6] = '{
        {12'd64,  4'h0, 11'd60,  6'h00},
        {12'd100, 4'h2, 11'd0,   6'h02},
        {12'd3,   4'h0, 11'd0,   6'h10},
        {12'd256, 4'h0, 11'd252, 6'h00},
        {12'd5,   4'h0, 11'd1,   6'h00},
        {12'd4,   4'h1, 11'd0,   6'h01}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int len, input logic [3:0] err, input logic [15:0] base);
        nwe = 0; nbad = 0; novr = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (ovr_pulse) novr++;
            in_valid = 1'b1;
            in_data  = 8'(i);
            in_last  = (i == len - 1);
            in_err   = (i == len - 1) ? err : 4'h0;
            #1;
            if (mem_we) begin
                nwe++;
                if (mem_addr != base + 16'(i) || mem_data != 8'(i)) nbad++;
            end
        end
        @(negedge clk);
        if (ovr_pulse) novr++;
        in_valid = 1'b0; in_last = 1'b0; in_err = 4'h0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_ret = 1'b1;
        @(negedge clk);
        rd_ret = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_status", int'(rd_status), 16'h8000);
        chk("R1 ovr_pulse", int'(ovr_pulse), 0);
        chk("R1 mem_we", int'(mem_we), 0);

        // table walk: R2 R3 R4 R6 R8 R10
        for (int k = 0; k < 6; k++) begin
            int len, e;
            logic [3:0] err;
            len = int'(VEC[k][32:21]);
            err = VEC[k][20:17];
            e   = k % 4;
            send_frame(len, err, 16'(e * 2048));
            chk("R2 bytes written", nwe, len);
            chk("R2 byte address", nbad, 0);
            chk("R3 rd_valid", int'(rd_valid), 1);
            chk("R3/R6 rd_len", int'(rd_len), int'(VEC[k][16:6]));
            chk("R6/R8 error flags", int'(rd_status[5:0]), int'(VEC[k][5:0]));
            chk("R6 rd_ok", int'(rd_ok), (VEC[k][5:0] == 6'h00) ? 1 : 0);
            chk("R4 wrap flag", int'(rd_status[13]), (e == 3) ? 1 : 0);
            chk("R11 rd_addr", int'(rd_addr), e * 2048);
            pop();
            chk("R10 empty after return", int'(rd_valid), 0);
        end

        // R5: return on empty is ignored, next frame lands in entry 2
        chk("R5 status empty", int'(rd_status), 16'h8000);
        pop();
        chk("R5 still empty", int'(rd_valid), 0);
        send_frame(20, 4'h0, 16'd4096);
        chk("R5 index kept", int'(rd_addr), 4096);
        chk("R5 frame length", int'(rd_len), 16);
        pop();

        // R11: new base for entry 3
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_addr = 16'h7000;
        @(negedge clk);
        cfg_we = 1'b0;
        send_frame(10, 4'h0, 16'h7000);
        chk("R11 bytes at new base", nbad, 0);
        chk("R11 rd_addr", int'(rd_addr), 16'h7000);

        // R9: fill remaining entries, then overrun
        send_frame(8, 4'h0, 16'd0);
        send_frame(8, 4'h0, 16'd2048);
        send_frame(8, 4'h0, 16'd4096);
        send_frame(6, 4'h0, 16'd0);
        chk("R9 no writes on drop", nwe, 0);
        chk("R9 one overrun pulse", novr, 1);
        chk("R9 entry kept", int'(rd_len), 6);
        chk("R9 entry base kept", int'(rd_addr), 16'h7000);
        pop();
        chk("R4 consumer wraps", int'(rd_addr), 0);
        chk("R9 entry0 length", int'(rd_len), 4);
        pop();
        chk("R10 next entry", int'(rd_addr), 2048);
        pop();
        chk("R10 entry2 length", int'(rd_len), 4);
        pop();
        chk("R10 ring drained", int'(rd_valid), 0);

        // R7: oversize frame, then frame of exactly the limit
        send_frame(MAXL + 5, 4'h0, 16'h7000);
        chk("R7 writes capped", nwe, MAXL);
        chk("R7 oversize flag", int'(rd_status[5:0]), 6'h20);
        chk("R7 no payload", int'(rd_len), 0);
        pop();
        send_frame(MAXL, 4'h0, 16'd0);
        chk("R7 limit frame ok", int'(rd_ok), 1);
        chk("R7 limit frame length", int'(rd_len), MAXL - 4);
        chk("R7 limit frame writes", nwe, MAXL);
        pop();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule